// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Pinned Entries

This block is a small, fully associative cache of page translations that sits in front of a page table walker. A lookup presents a virtual page number, the identifier of the running address space and an access type. In the same cycle the block reports one of three outcomes: a hit with the physical frame number and permission bits, a protection fault, or a miss. A fault means a matching entry exists but its permissions forbid the access.

After a miss, the walker writes its result back as a fill, so the next lookup of that page hits. Each entry carries its address-space tag, so a context switch does not require a flush. Entries can be pinned. A pinned entry is never evicted and survives every flush.

A flush can drop every unpinned entry, or only the unpinned entries of one address space. When a fill needs room, the block picks a victim in this order:

- the lowest-numbered empty slot;
- otherwise, a round-robin pointer that steps over pinned slots.

Top module: `tlb_asid`

## Requirements
- R1: A lookup hits only on a valid entry whose page number and address-space tag both equal the request; on a hit, `lk_pfn` and `lk_perm` carry the stored values combinationally in the same cycle.
- R2: With `lk_valid` high, exactly one of `lk_hit`, `lk_miss` and `lk_fault` is high. `lk_miss` is high when no entry matches. With `lk_valid` low, all three are low. `lk_pfn` and `lk_perm` read zero unless `lk_hit` is high.
- R3: Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. Access type 2'b00 is a read, 2'b01 a write, 2'b10 an execute, and 2'b11 is never allowed. A matching entry that lacks the needed bit raises `lk_fault`, not `lk_hit`.
- R4: A fill is written on the rising clock edge, so a lookup of the same page and tag hits from the next cycle on.
- R5: A fill whose page and tag equal those of a valid entry overwrites that entry, including its pinned flag, and creates no second copy.
- R6: A fill that needs a new slot takes the lowest-numbered invalid entry when one exists.
- R7: When every slot is valid, the victim is the first unpinned entry at or after a round-robin pointer, wrapping past the last slot. The pointer then moves to the slot after the victim. Reset sets the pointer to entry 0.
- R8: A pinned entry is never chosen as a victim and is never invalidated by a flush.
- R9: `flush_all` invalidates every unpinned entry.
- R10: `flush_asid` invalidates only the unpinned entries whose tag equals `flush_asid_val`.
- R11: An entry written by a fill stays valid even when a flush is requested in the same cycle.
- R12: If every entry is pinned and a fill matches none of them, the fill is dropped and `fill_rejected` is high for the one cycle after that clock edge; otherwise `fill_rejected` is low.
- R13: After reset no entry is valid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address-space tag of the request |
| lk_acc | input | 2 | Access type (00 read, 01 write, 10 execute, 11 never allowed) |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Matching entry forbids the access |
| lk_pfn | output | PFN_W | Physical frame number on a hit |
| lk_perm | output | 3 | Stored permission bits on a hit |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | Page number to write |
| fill_asid | input | ASID_W | Address-space tag to write |
| fill_pfn | input | PFN_W | Frame number to write |
| fill_perm | input | 3 | Permission bits to write |
| fill_wired | input | 1 | Pin the written entry |
| flush_all | input | 1 | Invalidate all unpinned entries |
| flush_asid | input | 1 | Invalidate unpinned entries of one tag |
| flush_asid_val | input | ASID_W | Tag selected by `flush_asid` |
| fill_rejected | output | 1 | Previous fill dropped because all entries are pinned |

## Verification
Several lookup patterns separate the match terms:

- the right page under the wrong tag;
- the right tag with the wrong page;
- the same page under two tags.

Together these show that both fields take part in the match. Each access type is run against an entry that allows read and write but not execute, which tells a fault apart from a hit and from a miss. The cache is then filled to capacity with one pinned slot and a single entry under a separate tag. Which page is lost on each later fill shows whether an empty slot is preferred over the round-robin pointer, and whether the pointer steps over the pinned slot. A fully pinned cache then checks the rejected-fill path. An unpin-by-refill followed by one more fill shows that the pointer wraps onto the only free slot.

// File: rtl/tlb_asid.sv
module tlb_asid #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_acc,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_fault,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [2:0]        lk_perm,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [2:0]        fill_perm,
  input  logic              fill_wired,
  input  logic              flush_all,
  input  logic              flush_asid,
  input  logic [ASID_W-1:0] flush_asid_val,
  output logic              fill_rejected
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW:0] NUM = (IW+1)'(ENTRIES);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES-1);

  logic [VPN_W-1:0]  vpn_q  [ENTRIES];
  logic [ASID_W-1:0] asid_q [ENTRIES];
  logic [PFN_W-1:0]  pfn_q  [ENTRIES];
  logic [2:0]        perm_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, wir_q;
  logic [IW-1:0] rr_q;

  logic [ENTRIES-1:0] lk_match, fl_match;
  logic [IW-1:0] lk_idx, fl_idx, free_idx, rr_idx, wr_idx;
  logic free_found, rr_found, fl_hit, do_write, allowed, any_match;
  logic [IW:0] step;
  logic [2:0] sel_perm;

  always_comb begin
    lk_idx = '0;
    fl_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_match[i] = vld_q[i] && vpn_q[i] == lk_vpn && asid_q[i] == lk_asid;
      fl_match[i] = vld_q[i] && vpn_q[i] == fill_vpn && asid_q[i] == fill_asid;
      if (lk_match[i]) lk_idx = IW'(i);
      if (fl_match[i]) fl_idx = IW'(i);
    end
  end

  always_comb begin
    free_found = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--)
      if (!vld_q[i] && !wir_q[i]) begin
        free_found = 1'b1;
        free_idx = IW'(i);
      end
  end

  always_comb begin
    rr_found = 1'b0;
    rr_idx = '0;
    step = '0;
    for (int k = ENTRIES-1; k >= 0; k--) begin
      step = {1'b0, rr_q} + (IW+1)'(k);
      if (step >= NUM) step = step - NUM;
      if (!wir_q[step[IW-1:0]]) begin
        rr_found = 1'b1;
        rr_idx = step[IW-1:0];
      end
    end
  end

  assign any_match = |lk_match;
  assign sel_perm  = perm_q[lk_idx];
  always_comb
    case (lk_acc)
      2'b00:   allowed = sel_perm[0];
      2'b01:   allowed = sel_perm[1];
      2'b10:   allowed = sel_perm[2];
      default: allowed = 1'b0;
    endcase

  assign lk_hit   = lk_valid && any_match && allowed;
  assign lk_fault = lk_valid && any_match && !allowed;
  assign lk_miss  = lk_valid && !any_match;
  assign lk_pfn   = lk_hit ? pfn_q[lk_idx] : '0;
  assign lk_perm  = lk_hit ? sel_perm : '0;

  assign fl_hit   = |fl_match;
  assign do_write = fill_en && (fl_hit || free_found || rr_found);
  assign wr_idx   = fl_hit ? fl_idx : (free_found ? free_idx : rr_idx);

  always_ff @(posedge clk)
    if (do_write) begin
      vpn_q[wr_idx]  <= fill_vpn;
      asid_q[wr_idx] <= fill_asid;
      pfn_q[wr_idx]  <= fill_pfn;
      perm_q[wr_idx] <= fill_perm;
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      wir_q <= '0;
      rr_q <= '0;
      fill_rejected <= 1'b0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (!wir_q[i] && (flush_all || (flush_asid && asid_q[i] == flush_asid_val)))
          vld_q[i] <= 1'b0;
      if (do_write) begin
        vld_q[wr_idx] <= 1'b1;
        wir_q[wr_idx] <= fill_wired;
      end
      if (fill_en && !fl_hit && !free_found && rr_found)
        rr_q <= (rr_idx == LAST) ? '0 : rr_idx + 1'b1;
      fill_rejected <= fill_en && !do_write;
    end
  end

  p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot({lk_hit, lk_miss, lk_fault}));
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_fault));
  p_pinned_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(vld_q & wir_q) & ~vld_q) == '0));
  p_reject_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fill_rejected |-> ($past(fill_en) && $past(&wir_q)));
  p_fill_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(&wir_q)) |=> (vld_q != '0));
endmodule

// File: tb/sim_tlb_asid.sv
module sim_tlb_asid;
  logic clk = 0, rst_n = 0;
  logic lk_valid = 0;
  logic [19:0] lk_vpn = 0;
  logic [7:0] lk_asid = 0;
  logic [1:0] lk_acc = 0;
  logic lk_hit, lk_miss, lk_fault;
  logic [19:0] lk_pfn;
  logic [2:0] lk_perm;
  logic fill_en = 0;
  logic [19:0] fill_vpn = 0;
  logic [7:0] fill_asid = 0;
  logic [19:0] fill_pfn = 0;
  logic [2:0] fill_perm = 0;
  logic fill_wired = 0;
  logic flush_all = 0, flush_asid = 0;
  logic [7:0] flush_asid_val = 0;
  logic fill_rejected;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  tlb_asid u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // kind: 0 miss, 1 hit, 2 fault
  task automatic look(input logic [19:0] v, input logic [7:0] a, input logic [1:0] acc,
                      input int kind, input logic [19:0] pfn, input string req);
    logic [31:0] got, exp;
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_asid = a; lk_acc = acc;
    #1;
    got = {lk_pfn, 9'd0, lk_hit, lk_miss, lk_fault};
    exp = {(kind == 1) ? pfn : 20'd0, 9'd0, kind == 1, kind == 0, kind == 2};
    chk(got == exp, req, got, exp);
    lk_valid = 0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p,
                      input logic [2:0] pm, input bit w, input bit rej, input string req);
    @(negedge clk);
    fill_en = 1; fill_vpn = v; fill_asid = a; fill_pfn = p; fill_perm = pm; fill_wired = w;
    @(posedge clk);
    @(negedge clk);
    fill_en = 0;
    chk(fill_rejected == rej, req, 32'(fill_rejected), 32'(rej));
  endtask

  task automatic flush(input bit all, input bit one, input logic [7:0] a);
    @(negedge clk);
    flush_all = all; flush_asid = one; flush_asid_val = a;
    @(negedge clk);
    flush_all = 0; flush_asid = 0;
  endtask

  task automatic t_reset;
    look(20'h10, 8'd1, 2'b00, 0, 0, "R13 reset miss");
    @(negedge clk);
    lk_valid = 0; #1;
    chk(!(lk_hit || lk_miss || lk_fault), "R2 idle quiet", {lk_hit, lk_miss, lk_fault}, 0);
  endtask

  task automatic t_basic;
    fill(20'h10, 8'd1, 20'hABC, 3'b011, 0, 0, "R12 normal fill not rejected");
    look(20'h10, 8'd1, 2'b00, 1, 20'hABC, "R1 R4 hit after fill");
    @(negedge clk);
    lk_valid = 1; lk_vpn = 20'h10; lk_asid = 8'd1; lk_acc = 2'b00; #1;
    chk(lk_perm == 3'b011, "R1 perm out", 32'(lk_perm), 3);
    lk_valid = 0;
    look(20'h10, 8'd2, 2'b00, 0, 0, "R1 wrong tag misses");
    look(20'h11, 8'd1, 2'b00, 0, 0, "R2 wrong page misses");
  endtask

  task automatic t_perm;
    look(20'h10, 8'd1, 2'b01, 1, 20'hABC, "R3 write allowed");
    look(20'h10, 8'd1, 2'b10, 2, 0, "R3 exec fault");
    look(20'h10, 8'd1, 2'b11, 2, 0, "R3 type 11 fault");
  endtask

  task automatic t_overwrite;
    fill(20'h10, 8'd1, 20'h123, 3'b111, 0, 0, "R5 refill");
    look(20'h10, 8'd1, 2'b10, 1, 20'h123, "R5 refill replaces");
  endtask

  task automatic t_flushes;
    fill(20'h20, 8'd2, 20'h222, 3'b001, 0, 0, "R4 fill tag2");
    fill(20'h10, 8'd2, 20'h777, 3'b001, 0, 0, "R4 fill same page tag2");
    flush(0, 1, 8'd1);
    look(20'h10, 8'd1, 2'b00, 0, 0, "R10 tag1 flushed");
    look(20'h20, 8'd2, 2'b00, 1, 20'h222, "R10 tag2 kept");
    look(20'h10, 8'd2, 2'b00, 1, 20'h777, "R10 same page other tag kept");
    fill(20'h30, 8'd3, 20'h333, 3'b001, 1, 0, "R8 pinned fill");
    flush(1, 0, 0);
    look(20'h30, 8'd3, 2'b00, 1, 20'h333, "R8 R9 pinned survives flush_all");
    look(20'h20, 8'd2, 2'b00, 0, 0, "R9 unpinned flushed");
    flush(0, 1, 8'd3);
    look(20'h30, 8'd3, 2'b00, 1, 20'h333, "R8 pinned survives flush_asid");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    fill_en = 1; fill_vpn = 20'h40; fill_asid = 8'd4; fill_pfn = 20'h444; fill_perm = 3'b001;
    fill_wired = 0; flush_all = 1;
    @(negedge clk);
    fill_en = 0; flush_all = 0;
    look(20'h40, 8'd4, 2'b00, 1, 20'h444, "R11 fill beats flush");
    flush(1, 0, 0);
    look(20'h40, 8'd4, 2'b00, 0, 0, "R9 later flush clears it");
  endtask

  task automatic t_round_robin;
    for (int k = 0; k < 63; k++)
      fill(20'h100 + 20'(k), (k == 40) ? 8'd6 : 8'd5, 20'h1000 + 20'(k), 3'b001, 0, 0, "R6 fill to capacity");
    fill(20'h200, 8'd5, 20'h2000, 3'b001, 0, 0, "R7 evicting fill");
    look(20'h100, 8'd5, 2'b00, 0, 0, "R7 first unpinned victim skips pinned slot");
    look(20'h200, 8'd5, 2'b00, 1, 20'h2000, "R7 new entry hits");
    look(20'h30, 8'd3, 2'b00, 1, 20'h333, "R8 pinned not victim");
    fill(20'h201, 8'd5, 20'h2001, 3'b001, 0, 0, "R7 second evicting fill");
    look(20'h101, 8'd5, 2'b00, 0, 0, "R7 pointer advanced");
    look(20'h102, 8'd5, 2'b00, 1, 20'h1002, "R7 next still present");
    flush(0, 1, 8'd6);
    fill(20'h300, 8'd5, 20'h3000, 3'b001, 0, 0, "R6 fill into hole");
    look(20'h102, 8'd5, 2'b00, 1, 20'h1002, "R6 hole preferred over pointer");
    look(20'h300, 8'd5, 2'b00, 1, 20'h3000, "R6 hole filled");
    fill(20'h301, 8'd5, 20'h3001, 3'b001, 0, 0, "R7 evict after hole");
    look(20'h102, 8'd5, 2'b00, 0, 0, "R7 pointer held across hole fill");
  endtask

  task automatic t_all_pinned;
    flush(1, 0, 0);
    for (int k = 0; k < 63; k++)
      fill(20'h500 + 20'(k), 8'd7, 20'h5000 + 20'(k), 3'b001, 1, 0, "R8 pin all");
    fill(20'h400, 8'd7, 20'h4000, 3'b001, 0, 1, "R12 rejected when all pinned");
    look(20'h400, 8'd7, 2'b00, 0, 0, "R12 dropped fill misses");
    look(20'h53E, 8'd7, 2'b00, 1, 20'h503E, "R12 pinned intact");
    fill(20'h30, 8'd3, 20'h335, 3'b001, 0, 0, "R5 refill of pinned accepted");
    look(20'h30, 8'd3, 2'b00, 1, 20'h335, "R5 pinned refill data");
    fill(20'h400, 8'd7, 20'h4000, 3'b001, 0, 0, "R5 unpinned slot usable");
    look(20'h30, 8'd3, 2'b00, 0, 0, "R5 R7 unpinned entry evicted after wrap");
    look(20'h400, 8'd7, 2'b00, 1, 20'h4000, "R7 wrapped victim filled");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_basic;
    t_perm;
    t_overwrite;
    t_flushes;
    t_same_cycle;
    t_round_robin;
    t_all_pinned;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule